// File: doc/BRIEF.md
# Photon Delay Calibration Controller

This controller sets a programmable delay line so that a single-photon detection lands at the leading edge of a short receiver gating window. A host start command begins a calibration run. The controller first sweeps the delay forward in large steps until detections appear. It then walks the delay backward in small steps until detections stop, and moves forward again by one small step. A mixer-enable flag is high only while the run is in progress. A completion flag tells the host that the run has finished.

Detections reach the controller as asynchronous pulses. There are two receiver strobes and a fallback photon-valid line. All of them pass through two-flop synchronizers and rising-edge detectors. A per-sync-period tick marks each trial, and each trial records at most one detection. The number of trials per decision, N, is a parameter. Every pin is a plain control or status signal, and no pin carries a data stream. For that reason the block has no valid/ready handshake and no back-pressure rules.

Top module: `pdc_ctrl`

## Requirements
- R1: A one-cycle `start_i` pulse, accepted in any state, sets `delay_code_o` to 0, clears the trial count, drives `mix_en_o` to 1, and drives `sync_end_o` and `cal_err_o` to 0 on the next clock edge. A start during a run restarts that run.
- R2: In the coarse phase, N consecutive tick periods without a detection raise the code by 20. The code LSB is 0.25 ns, so 20 LSBs make one 5 ns step. The trial count then restarts.
- R3: A tick period with a detection in the coarse phase moves the controller to the fine phase and lowers the code by 1. Each later tick period with a detection in the fine phase lowers the code by 1 and restarts the trial count. The code never goes below 0.
- R4: In the fine phase, N consecutive tick periods without a detection raise the code by 1 and end the run with `sync_end_o`=1 and `mix_en_o`=0. The code then holds until the next start.
- R5: `mix_en_o` is 1 exactly while a run is in its coarse or fine phase, and 0 after reset and after a run ends.
- R6: When `strobe_avail_i`=1, a detection is a rising edge on any bit of `strobe_i`, and `photon_valid_i` is ignored. When `strobe_avail_i`=0, a detection is a rising edge on `photon_valid_i`, and `strobe_i` is ignored. An edge counts toward a tick when it reaches the pins at least 3 clock cycles before the tick.
- R7: A tick period counts at most one detection, however many edges arrive within it. One such period moves the code by at most one fine step.
- R8: `delay_code_o` is 8 bits wide and saturates at 255 on a coarse step rather than wrapping. If a coarse round of N missed periods completes while the code is already 255, the run stops with `cal_err_o`=1, `sync_end_o`=1 and `mix_en_o`=0.
- R9: After reset the controller is idle with code 0 and all flags at 0. While idle, ticks and detections leave the code and the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle calibration start command, synchronous |
| strobe_i | input | 2 | Receiver detection strobes, asynchronous |
| strobe_avail_i | input | 1 | 1: the strobes are the detection source; 0: use photon_valid_i |
| photon_valid_i | input | 1 | Fallback detection pulse, asynchronous |
| tick_i | input | 1 | One-cycle pulse once per sync period; closes a trial |
| delay_code_o | output | 8 | Binary delay-line code, 0.25 ns per LSB |
| mix_en_o | output | 1 | High while calibration runs |
| sync_end_o | output | 1 | Run finished (success or failure) |
| cal_err_o | output | 1 | Coarse sweep exhausted the range without a detection |

## Verification
The assertions take the following for granted about the inputs:
- `start_i` and `tick_i` are synchronous pulses one cycle wide.
- `strobe_avail_i` does not change during a run.
- Every detection pulse lasts at least one clock cycle, so the synchronizer samples it.

The stimulus drives each detection pulse for two cycles. It waits four more cycles before issuing a tick, so every edge settles into the trial it was meant for. The source select is changed only between runs.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COARSE,
    ST_FINE,
    ST_DONE,
    ST_FAIL
  } cal_state_e;
endpackage

// File: rtl/pdc_sync.sv
module pdc_sync #(
  parameter int WIDTH = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] rise_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic meta_q, stab_q, prev_q;
    always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= async_i[g];
        stab_q <= meta_q;
        prev_q <= stab_q;
      end
    end
    assign rise_o[g] = stab_q & ~prev_q;

    // R6: an edge is reported only for an input that was high two cycles earlier
    assert_rise_source_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o[g] |-> $past(async_i[g], 2));
  end
endmodule

// File: rtl/pdc_trial.sv
module pdc_trial #(
  parameter int N_TRIALS = 4,
  localparam int CW = $clog2(N_TRIALS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  input  logic tick_i,
  input  logic det_i,
  output logic hit_o,
  output logic round_done_o
);
  logic [CW-1:0] cnt_q;
  logic          seen_q;

  assign hit_o        = seen_q | det_i;
  assign round_done_o = en_i & tick_i & ~hit_o & (cnt_q == CW'(N_TRIALS - 1));

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      if (tick_i)     seen_q <= 1'b0;
      else if (det_i) seen_q <= 1'b1;
      if (en_i && tick_i) begin
        if (hit_o || round_done_o) cnt_q <= '0;
        else                       cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assert_cnt_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(N_TRIALS));
  // R7: a tick closes the window, so nothing carries into the next period
  assert_one_per_tick_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !clr_i) |=> !seen_q);
endmodule

// File: rtl/pdc_fsm.sv
module pdc_fsm
  import pdc_pkg::*;
#(
  parameter int CODE_W      = 8,
  parameter int COARSE_STEP = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              tick_i,
  input  logic              hit_i,
  input  logic              round_done_i,
  output logic [CODE_W-1:0] code_o,
  output cal_state_e        state_o
);
  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

  cal_state_e        st_q, st_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic [CODE_W:0]   coarse_sum;
  logic [CODE_W-1:0] code_up_coarse, code_up_fine, code_down;

  assign coarse_sum     = {1'b0, code_q} + (CODE_W+1)'(COARSE_STEP);
  assign code_up_coarse = (coarse_sum > {1'b0, CODE_MAX}) ? CODE_MAX : coarse_sum[CODE_W-1:0];
  assign code_up_fine   = (code_q == CODE_MAX) ? CODE_MAX : code_q + 1'b1;
  assign code_down      = (code_q == '0) ? '0 : code_q - 1'b1;

  always_comb begin
    st_d   = st_q;
    code_d = code_q;
    if (start_i) begin
      st_d   = ST_COARSE;
      code_d = '0;
    end else begin
      case (st_q)
        ST_COARSE: if (tick_i) begin
          if (hit_i) begin
            st_d   = ST_FINE;
            code_d = code_down;
          end else if (round_done_i) begin
            if (code_q == CODE_MAX) st_d = ST_FAIL;
            else                    code_d = code_up_coarse;
          end
        end
        ST_FINE: if (tick_i) begin
          if (hit_i) begin
            code_d = code_down;
          end else if (round_done_i) begin
            code_d = code_up_fine;
            st_d   = ST_DONE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      code_q <= '0;
    end else begin
      st_q   <= st_d;
      code_q <= code_d;
    end
  end

  assign code_o  = code_q;
  assign state_o = st_q;

  assert_start_clears_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (code_q == '0 && st_q == ST_COARSE));
  assert_coarse_no_fall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_COARSE && !start_i && !hit_i) |=> (code_q >= $past(code_q)));
  assert_fine_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_FINE && !start_i) |=> ({1'b0, code_q} <= {1'b0, $past(code_q)} + 1'b1));
  assert_end_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_DONE || st_q == ST_FAIL) && !start_i) |=> ($stable(code_q) && st_q == $past(st_q)));
  assert_fail_at_max_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_FAIL) |-> (code_q == CODE_MAX));
  assert_idle_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) |-> (code_q == '0));
endmodule

// File: rtl/pdc_ctrl.sv
module pdc_ctrl
  import pdc_pkg::*;
#(
  parameter int N_TRIALS    = 4,
  parameter int NUM_STROBES = 2,
  parameter int CODE_W      = 8,
  parameter int COARSE_STEP = 20
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [NUM_STROBES-1:0] strobe_i,
  input  logic                   strobe_avail_i,
  input  logic                   photon_valid_i,
  input  logic                   tick_i,
  output logic [CODE_W-1:0]      delay_code_o,
  output logic                   mix_en_o,
  output logic                   sync_end_o,
  output logic                   cal_err_o
);
  localparam int SRC_W = NUM_STROBES + 1;

  logic [SRC_W-1:0] rise;
  logic             det, hit, round_done, active;
  cal_state_e       state;

  pdc_sync #(.WIDTH(SRC_W)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({photon_valid_i, strobe_i}),
    .rise_o  (rise)
  );

  assign det    = strobe_avail_i ? |rise[NUM_STROBES-1:0] : rise[NUM_STROBES];
  assign active = (state == ST_COARSE) || (state == ST_FINE);

  pdc_trial #(.N_TRIALS(N_TRIALS)) u_trial (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_i        (start_i),
    .en_i         (active),
    .tick_i       (tick_i),
    .det_i        (det),
    .hit_o        (hit),
    .round_done_o (round_done)
  );

  pdc_fsm #(.CODE_W(CODE_W), .COARSE_STEP(COARSE_STEP)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .tick_i       (tick_i),
    .hit_i        (hit),
    .round_done_i (round_done),
    .code_o       (delay_code_o),
    .state_o      (state)
  );

  assign mix_en_o   = active;
  assign sync_end_o = (state == ST_DONE) || (state == ST_FAIL);
  assign cal_err_o  = (state == ST_FAIL);

  assert_mix_vs_end_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mix_en_o && sync_end_o));
  assert_err_ends_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_err_o |-> sync_end_o);
  assert_start_mix_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (mix_en_o && !sync_end_o && !cal_err_o));
endmodule

// File: tb/pdc_ctrl_tb.sv
module pdc_ctrl_tb;
  localparam int N = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [1:0] strobe_i = 2'b00;
  logic       strobe_avail_i = 1'b1;
  logic       photon_valid_i = 1'b0;
  logic       tick_i = 1'b0;
  logic [7:0] code;
  logic       mix_en, sync_end, cal_err;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pdc_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .strobe_i(strobe_i),
    .strobe_avail_i(strobe_avail_i), .photon_valid_i(photon_valid_i), .tick_i(tick_i),
    .delay_code_o(code), .mix_en_o(mix_en), .sync_end_o(sync_end), .cal_err_o(cal_err)
  );

  // fields: [23:16] coarse rounds, [15:8] extra fine hits, [7:0] source 0/1 strobe, 2 fallback
  localparam logic [23:0] VEC [0:3] = '{
    {8'd0, 8'd0, 8'd0},
    {8'd2, 8'd3, 8'd1},
    {8'd1, 8'd0, 8'd2},
    {8'd3, 8'd2, 8'd0}
  };

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic pulse(int src);
    @(negedge clk);
    if (src == 2) photon_valid_i = 1'b1; else strobe_i[src] = 1'b1;
    repeat (2) @(negedge clk);
    photon_valid_i = 1'b0;
    strobe_i = 2'b00;
    repeat (4) @(negedge clk);
  endtask

  task automatic tick();
    repeat (2) @(negedge clk);
    tick_i = 1'b1;
    @(negedge clk) tick_i = 1'b0;
  endtask

  task automatic miss_round();
    for (int i = 0; i < N; i++) tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state and idle behaviour
    chk("R9 code", code, 0);
    chk("R9 flags", {mix_en, sync_end, cal_err}, 0);
    pulse(0); tick(); miss_round();
    chk("R9 idle ignores", {code, mix_en, sync_end}, 0);

    for (int v = 0; v < 4; v++) begin
      int k = VEC[v][23:16];
      int f = VEC[v][15:8];
      int src = VEC[v][7:0];
      int e;
      strobe_avail_i = (src != 2);
      do_start();
      chk("R1 code", code, 0);
      chk("R5 mix high", mix_en, 1);
      for (int r = 0; r < k; r++) miss_round();
      e = (20 * k > 255) ? 255 : 20 * k;
      chk("R2 coarse", code, e);
      for (int h = 0; h <= f; h++) begin
        pulse(src); tick();
        e = (e > 0) ? e - 1 : 0;
      end
      chk("R3 fine", code, e);
      miss_round();
      e = e + 1;
      chk("R4 final", code, e);
      chk("R4 end flags", {sync_end, mix_en, cal_err}, 3'b100);
    end

    // R6 source select: unused source is ignored
    strobe_avail_i = 1'b1;
    do_start();
    pulse(2); tick();
    for (int i = 1; i < N; i++) tick();
    chk("R6 valid ignored", code, 20);
    strobe_avail_i = 1'b0;
    do_start();
    pulse(0); tick();
    for (int i = 1; i < N; i++) tick();
    chk("R6 strobe ignored", code, 20);

    // R7 one detection per tick period
    strobe_avail_i = 1'b1;
    do_start();
    miss_round();
    pulse(0); pulse(1); tick();
    chk("R7 single step", code, 19);
    pulse(1); pulse(1); tick();
    chk("R7 single step fine", code, 18);
    // R1 restart mid-run
    do_start();
    chk("R1 restart code", code, 0);
    chk("R1 restart flags", {mix_en, sync_end, cal_err}, 3'b100);

    // R8 saturation and failure
    for (int r = 0; r < 13; r++) miss_round();
    chk("R8 saturate", code, 255);
    chk("R8 still running", mix_en, 1);
    miss_round();
    chk("R8 fail flags", {cal_err, sync_end, mix_en}, 3'b110);
    chk("R8 code held", code, 255);
    do_start();
    chk("R1 clears error", {cal_err, sync_end, code}, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule